// File: doc/BRIEF.md
# Barrel-Scheduled Multi-Context Processor Sequencer

This block makes one shared execution stage look like ten independent 12-bit processors. The live state of every processor (accumulator, program address, a latched opcode and operand field, a secondary address and a step counter) sits in a ring of ten state registers. The ring shifts by one position every clock. On each clock the context at the head of the ring passes through a combinational slot. The slot carries out one step of that context's current instruction and puts the updated state back in at the tail. Each context therefore gets the slot once every ten clocks, and one full trip of the ring counts as that processor's basic machine cycle.

Every context owns a private word memory, 12 bits wide. The memory is read only while its context occupies the slot, so it sees at most one access per ring trip. Short instructions take one 12-bit word and finish in a single visit. Long instructions carry a second word holding a 12-bit address and need further visits, which the step counter tracks. Contexts come out of reset halted so that their memories can be loaded through a test write port. A per-context start input releases a context, and a halt opcode stops it again. A halted context keeps its state while the ring goes on rotating.

The head of the ring is visible at the ports: the index of the context now in the slot and the state it brings in. That state is the result of the context's previous visit.

Top module: `barrel_seq`

## Requirements
- R1: After reset every context holds accumulator 0, program address 0, step 0 and halt set, and the first context presented at the slot is context 0.
- R2: The context index at the slot advances by one on every clock after reset and wraps from 9 to 0, so every context is presented exactly once in ten clocks.
- R3: A halted context whose start bit is low during its visit leaves the slot with accumulator, program address, step and halt unchanged.
- R4: A halted context whose start bit is high during its visit clears its halt bit and executes nothing on that visit. Its next visit fetches the word at its program address.
- R5: An instruction word holds the opcode in bits [11:6] and a 6-bit field F in bits [5:0]. Short immediate opcodes take one visit and advance the program address by one. With F zero-extended, they are: 0x01 load (acc=F), 0x02 add (acc+F), 0x03 subtract (acc-F), 0x04 AND, 0x05 XOR. Arithmetic wraps modulo 2^18.
- R6: Opcode 0x06 adds F, sign-extended to 12 bits, to the program address when the accumulator is zero, and opcode 0x07 does so when it is nonzero. Otherwise the program address advances by one. Both take one visit.
- R7: Opcode 0x08 is a long jump. The first visit leaves step 1 and the program address at the second word. The second visit loads the program address from that word and returns step to 0.
- R8: Opcodes 0x09 (load from memory) and 0x0A (add from memory) are long. Visit one leaves step 1. Visit two latches the second word as an operand address, advances the program address past it and leaves step 2. Visit three reads that address, loads or adds the zero-extended word, and returns step to 0.
- R9: Opcode 0x00 sets halt and leaves the program address and accumulator unchanged.
- R10: Each context reads only its own memory. Test-port writes go to the memory selected by `tp_ctx`, and memory addresses are taken modulo the memory depth 2^MEM_AW.
- R11: Any opcode not listed above (0x0B to 0x3F) is a one-visit no-op that advances the program address by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | NCTX | Per-context release; bit i is sampled while context i is in the slot |
| tp_we | input | 1 | Test-port memory write enable |
| tp_ctx | input | CTX_W | Context whose memory the test port writes |
| tp_addr | input | MEM_AW | Test-port word address |
| tp_data | input | 12 | Test-port write data |
| cur_ctx | output | CTX_W | Index of the context now in the slot |
| cur_acc | output | 18 | Accumulator of the context in the slot |
| cur_pc | output | 12 | Program address of the context in the slot |
| cur_step | output | 3 | Step counter of the context in the slot |
| cur_halt | output | 1 | Halt bit of the context in the slot |

## Verification
A corrupted ring entry, or a wrong slot result, becomes visible at the ports exactly ten clocks after it is written, when that context returns to the head. Each context's stream of observed states is therefore compared visit by visit against an independent per-context model of the instruction set. A mistake is caught on the very next visit of the context it touched. A fault that moves state between contexts, or addresses the wrong private memory, shows up as one context's trace drifting from its own program. A fault in the rotation shows at once as a break in the context-index sequence.

// File: rtl/barrel_pkg.sv
package barrel_pkg;

  localparam int ACC_W  = 18;
  localparam int WORD_W = 12;
  localparam int OPC_W  = 6;
  localparam int FLD_W  = 6;
  localparam int STEP_W = 3;

  // Step counter values for instruction progress
  localparam logic [STEP_W-1:0] STEP_FETCH = 3'd0;
  localparam logic [STEP_W-1:0] STEP_WORD2 = 3'd1;
  localparam logic [STEP_W-1:0] STEP_OPND  = 3'd2;

  // Opcode values
  localparam logic [OPC_W-1:0] OP_HALT = 6'h00;
  localparam logic [OPC_W-1:0] OP_LDI  = 6'h01;
  localparam logic [OPC_W-1:0] OP_ADI  = 6'h02;
  localparam logic [OPC_W-1:0] OP_SBI  = 6'h03;
  localparam logic [OPC_W-1:0] OP_ANI  = 6'h04;
  localparam logic [OPC_W-1:0] OP_XRI  = 6'h05;
  localparam logic [OPC_W-1:0] OP_BZR  = 6'h06;
  localparam logic [OPC_W-1:0] OP_BNZ  = 6'h07;
  localparam logic [OPC_W-1:0] OP_JMP  = 6'h08;
  localparam logic [OPC_W-1:0] OP_LDM  = 6'h09;
  localparam logic [OPC_W-1:0] OP_ADM  = 6'h0A;

  typedef struct packed {
    logic              halt;
    logic [STEP_W-1:0] step;
    logic [OPC_W-1:0]  opc;
    logic [FLD_W-1:0]  fld;
    logic [WORD_W-1:0] adr;
    logic [WORD_W-1:0] pc;
    logic [ACC_W-1:0]  acc;
  } ctx_t;

  localparam ctx_t CTX_RST = '{halt: 1'b1, step: STEP_FETCH, opc: '0,
                               fld: '0, adr: '0, pc: '0, acc: '0};

endpackage

// File: rtl/barrel_mem.sv
module barrel_mem #(
  parameter int NCTX   = 10,
  parameter int MEM_AW = 8,
  localparam int CTX_W = $clog2(NCTX),
  localparam int DEPTH = 2 ** MEM_AW
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [CTX_W-1:0]          wr_ctx,
  input  logic [MEM_AW-1:0]         wr_addr,
  input  logic [barrel_pkg::WORD_W-1:0] wr_data,
  input  logic [CTX_W-1:0]          rd_ctx,
  input  logic [barrel_pkg::WORD_W-1:0] rd_addr,
  output logic [barrel_pkg::WORD_W-1:0] rd_data
);
  import barrel_pkg::*;

  logic [MEM_AW-1:0] rd_idx;
  logic [WORD_W-1:0] bank_rd [NCTX];

  // program addresses wrap onto the bank depth
  assign rd_idx = MEM_AW'(rd_addr % DEPTH);

  for (genvar g = 0; g < NCTX; g++) begin : g_bank
    logic [WORD_W-1:0] arr [DEPTH];
    logic              bank_we;

    assign bank_we = wr_en && (wr_ctx == CTX_W'(g));

    always_ff @(posedge clk) begin
      if (bank_we) begin
        arr[wr_addr] <= wr_data;
      end
    end

    assign bank_rd[g] = arr[rd_idx];
  end

  assign rd_data = bank_rd[rd_ctx];

endmodule

// File: rtl/barrel_ring.sv
module barrel_ring #(
  parameter int NCTX = 10,
  localparam int CTX_W = $clog2(NCTX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv_en,
  input  barrel_pkg::ctx_t   tail_in,
  output barrel_pkg::ctx_t   head_out,
  output logic [CTX_W-1:0]   head_id
);
  import barrel_pkg::*;

  ctx_t             ring_q [NCTX];
  ctx_t             ring_d [NCTX];
  logic [CTX_W-1:0] id_q;
  logic [CTX_W-1:0] id_d;

  // next state: every entry moves one place toward the head
  for (genvar g = 0; g < NCTX - 1; g++) begin : g_shift
    assign ring_d[g] = ring_q[g+1];
  end
  assign ring_d[NCTX-1] = tail_in;

  always_comb begin
    if (id_q == CTX_W'(NCTX - 1)) begin
      id_d = '0;
    end else begin
      id_d = id_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCTX; i++) begin
        ring_q[i] <= CTX_RST;
      end
      id_q <= '0;
    end else if (adv_en) begin
      for (int i = 0; i < NCTX; i++) begin
        ring_q[i] <= ring_d[i];
      end
      id_q <= id_d;
    end
  end

  assign head_out = ring_q[0];
  assign head_id  = id_q;

endmodule

// File: rtl/barrel_slot.sv
module barrel_slot (
  input  barrel_pkg::ctx_t                  cur,
  input  logic                              start,
  input  logic [barrel_pkg::WORD_W-1:0]     mem_rd,
  output logic [barrel_pkg::WORD_W-1:0]     mem_addr,
  output barrel_pkg::ctx_t                  nxt
);
  import barrel_pkg::*;

  logic [OPC_W-1:0]  w_opc;
  logic [FLD_W-1:0]  w_fld;
  logic [ACC_W-1:0]  fld_zx;
  logic [ACC_W-1:0]  mem_zx;
  logic [WORD_W-1:0] fld_sx;
  logic [WORD_W-1:0] pc_inc;
  logic              acc_zero;

  assign w_opc    = mem_rd[WORD_W-1 -: OPC_W];
  assign w_fld    = mem_rd[FLD_W-1:0];
  assign fld_zx   = {{(ACC_W-FLD_W){1'b0}}, w_fld};
  assign mem_zx   = {{(ACC_W-WORD_W){1'b0}}, mem_rd};
  assign fld_sx   = {{(WORD_W-FLD_W){w_fld[FLD_W-1]}}, w_fld};
  assign pc_inc   = cur.pc + 1'b1;
  assign acc_zero = (cur.acc == '0);

  // the operand step reads through the latched address, all others at pc
  assign mem_addr = (cur.step == STEP_OPND) ? cur.adr : cur.pc;

  always_comb begin
    nxt = cur;
    if (cur.halt) begin
      if (start) begin
        nxt.halt = 1'b0;
      end
    end else begin
      case (cur.step)
        STEP_FETCH: begin
          nxt.opc = w_opc;
          nxt.fld = w_fld;
          nxt.pc  = pc_inc;
          case (w_opc)
            OP_HALT: begin
              nxt.halt = 1'b1;
              nxt.pc   = cur.pc;
            end
            OP_LDI: nxt.acc = fld_zx;
            OP_ADI: nxt.acc = cur.acc + fld_zx;
            OP_SBI: nxt.acc = cur.acc - fld_zx;
            OP_ANI: nxt.acc = cur.acc & fld_zx;
            OP_XRI: nxt.acc = cur.acc ^ fld_zx;
            OP_BZR: if (acc_zero) nxt.pc = cur.pc + fld_sx;
            OP_BNZ: if (!acc_zero) nxt.pc = cur.pc + fld_sx;
            OP_JMP, OP_LDM, OP_ADM: nxt.step = STEP_WORD2;
            default: ;
          endcase
        end
        STEP_WORD2: begin
          if (cur.opc == OP_JMP) begin
            nxt.pc   = mem_rd;
            nxt.step = STEP_FETCH;
          end else begin
            nxt.adr  = mem_rd;
            nxt.pc   = pc_inc;
            nxt.step = STEP_OPND;
          end
        end
        STEP_OPND: begin
          nxt.step = STEP_FETCH;
          if (cur.opc == OP_LDM) begin
            nxt.acc = mem_zx;
          end else begin
            nxt.acc = cur.acc + mem_zx;
          end
        end
        default: nxt.step = STEP_FETCH;
      endcase
    end
  end

endmodule

// File: rtl/barrel_seq.sv
module barrel_seq #(
  parameter int NCTX   = 10,
  parameter int MEM_AW = 8,
  localparam int CTX_W = $clog2(NCTX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCTX-1:0]   start,
  input  logic              tp_we,
  input  logic [CTX_W-1:0]  tp_ctx,
  input  logic [MEM_AW-1:0] tp_addr,
  input  logic [11:0]       tp_data,
  output logic [CTX_W-1:0]  cur_ctx,
  output logic [17:0]       cur_acc,
  output logic [11:0]       cur_pc,
  output logic [2:0]        cur_step,
  output logic              cur_halt
);
  import barrel_pkg::*;

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  ctx_t              slot_in;
  ctx_t              slot_out;
  logic [CTX_W-1:0]  slot_id;
  logic              start_sel;
  logic [WORD_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_rd;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[1];

  assign start_sel = start[slot_id];

  barrel_ring #(.NCTX(NCTX)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .adv_en   (1'b1),
    .tail_in  (slot_out),
    .head_out (slot_in),
    .head_id  (slot_id)
  );

  barrel_slot u_slot (
    .cur      (slot_in),
    .start    (start_sel),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .nxt      (slot_out)
  );

  barrel_mem #(.NCTX(NCTX), .MEM_AW(MEM_AW)) u_mem (
    .clk     (clk),
    .wr_en   (tp_we),
    .wr_ctx  (tp_ctx),
    .wr_addr (tp_addr),
    .wr_data (tp_data),
    .rd_ctx  (slot_id),
    .rd_addr (mem_addr),
    .rd_data (mem_rd)
  );

  assign cur_ctx  = slot_id;
  assign cur_acc  = slot_in.acc;
  assign cur_pc   = slot_in.pc;
  assign cur_step = slot_in.step;
  assign cur_halt = slot_in.halt;

endmodule

// File: rtl/barrel_seq_chk.sv
module barrel_seq_chk #(
  parameter int NCTX = 10,
  localparam int CTX_W = $clog2(NCTX)
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic [CTX_W-1:0]  cur_ctx,
  input logic [2:0]        cur_step,
  input logic              cur_halt,
  input logic              start_sel,
  input barrel_pkg::ctx_t  slot_in,
  input barrel_pkg::ctx_t  slot_out
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
    end
  end

  // R2
  ctx_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    cur_ctx == (($past(cur_ctx) == CTX_W'(NCTX - 1)) ? '0 : $past(cur_ctx) + 1'b1));

  // R3
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (slot_in.halt && !start_sel) |-> (slot_out == slot_in));

  // R8
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    cur_step <= 3'd2);

  // R9
  halt_at_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    cur_halt |-> (cur_step == 3'd0));

  // R4
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (slot_in.halt && start_sel) |-> (!slot_out.halt && slot_out.pc == slot_in.pc
                                     && slot_out.acc == slot_in.acc));

endmodule

bind barrel_seq barrel_seq_chk #(.NCTX(NCTX)) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .cur_ctx   (cur_ctx),
  .cur_step  (cur_step),
  .cur_halt  (cur_halt),
  .start_sel (start_sel),
  .slot_in   (slot_in),
  .slot_out  (slot_out)
);

// File: tb/barrel_seq_test.sv
`timescale 1ns/1ps
module barrel_seq_test;

  localparam int NCTX  = 10;
  localparam int AW    = 8;
  localparam int DEP   = 2 ** AW;
  localparam int NV    = 40;
  localparam logic [NCTX-1:0] RUN_MASK = 10'b00_1110_1111; // ctx 0,1,2,3,5,6,7

  typedef struct {
    int          c;
    int          v;
    logic [17:0] acc;
    logic [11:0] pc;
    logic [2:0]  step;
    logic        halt;
    string       tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NCTX-1:0] start;
  logic            tp_we;
  logic [3:0]      tp_ctx;
  logic [AW-1:0]   tp_addr;
  logic [11:0]     tp_data;
  logic [3:0]      cur_ctx;
  logic [17:0]     cur_acc;
  logic [11:0]     cur_pc;
  logic [2:0]      cur_step;
  logic            cur_halt;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;
  exp_t sb [$];

  logic [11:0] img  [NCTX][DEP];
  logic [17:0] m_acc [NCTX];
  logic [11:0] m_pc  [NCTX];
  logic [11:0] m_adr [NCTX];
  logic [5:0]  m_opc [NCTX];
  logic [2:0]  m_stp [NCTX];
  logic        m_hlt [NCTX];

  always #2.5 clk = ~clk;

  barrel_seq #(.NCTX(NCTX), .MEM_AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tp_we(tp_we), .tp_ctx(tp_ctx),
    .tp_addr(tp_addr), .tp_data(tp_data), .cur_ctx(cur_ctx), .cur_acc(cur_acc),
    .cur_pc(cur_pc), .cur_step(cur_step), .cur_halt(cur_halt)
  );

  function automatic logic [11:0] w(input int op, input int f);
    return 12'((op << 6) | (f & 63));
  endfunction

  // independent reference of one slot visit, written from the requirements
  task automatic model_visit(input int c, input bit st, output string tag);
    logic [11:0] word;
    logic [5:0]  op;
    logic [5:0]  f;
    word = img[c][(m_stp[c] == 3'd2 ? m_adr[c] : m_pc[c]) % DEP];
    op = word[11:6];
    f  = word[5:0];
    if (m_hlt[c]) begin
      if (st) begin m_hlt[c] = 1'b0; tag = "R4"; end
      else tag = "R3";
    end else if (m_stp[c] == 3'd0) begin
      m_opc[c] = op;
      tag = "R5";
      case (op)
        6'h00: begin m_hlt[c] = 1'b1; tag = "R9"; end
        6'h01: m_acc[c] = {12'd0, f};
        6'h02: m_acc[c] = m_acc[c] + {12'd0, f};
        6'h03: m_acc[c] = m_acc[c] - {12'd0, f};
        6'h04: m_acc[c] = m_acc[c] & {12'd0, f};
        6'h05: m_acc[c] = m_acc[c] ^ {12'd0, f};
        default: ;
      endcase
      if (op != 6'h00) m_pc[c] = m_pc[c] + 1;
      if (op == 6'h06 || op == 6'h07) begin
        tag = "R6";
        if ((op == 6'h06) == (m_acc[c] == 0))
          m_pc[c] = m_pc[c] - 1 + {{6{f[5]}}, f};
      end
      if (op == 6'h08) begin m_stp[c] = 3'd1; tag = "R7"; end
      if (op == 6'h09 || op == 6'h0A) begin m_stp[c] = 3'd1; tag = "R8"; end
      if (op > 6'h0A) tag = "R11";
    end else if (m_stp[c] == 3'd1) begin
      if (m_opc[c] == 6'h08) begin
        m_pc[c] = word; m_stp[c] = 3'd0; tag = "R7";
      end else begin
        m_adr[c] = word; m_pc[c] = m_pc[c] + 1; m_stp[c] = 3'd2; tag = "R8";
      end
    end else begin
      m_stp[c] = 3'd0;
      tag = "R8";
      if (m_opc[c] == 6'h09) m_acc[c] = {6'd0, word};
      else m_acc[c] = m_acc[c] + {6'd0, word};
    end
  endtask

  // driver: pushes the expected state for every visit of one context
  task automatic push_expected(input int c);
    string tag;
    exp_t  e;
    m_acc[c] = '0; m_pc[c] = '0; m_adr[c] = '0; m_opc[c] = '0;
    m_stp[c] = '0; m_hlt[c] = 1'b1;
    tag = "R1";
    for (int v = 0; v < NV; v++) begin
      e.c = c; e.v = v; e.acc = m_acc[c]; e.pc = m_pc[c];
      e.step = m_stp[c]; e.halt = m_hlt[c];
      e.tag = (c >= 1 && c <= 3 && v > 0) ? {tag, ",R10"} : tag;
      sb.push_back(e);
      model_visit(c, (v == 0) && RUN_MASK[c], tag);
    end
  endtask

  task automatic build_images();
    for (int c = 0; c < NCTX; c++)
      for (int a = 0; a < DEP; a++) img[c][a] = 12'h000;
    // ctx0: immediate arithmetic and logic, then halt
    img[0][0] = w(1, 5);  img[0][1] = w(2, 63); img[0][2] = w(3, 1);
    img[0][3] = w(4, 42); img[0][4] = w(5, 63); img[0][5] = w(0, 0);
    // ctx1: load and add from memory, long jump
    img[1][0] = w(9, 0);  img[1][1] = 12'h080; img[1][2] = w(10, 0);
    img[1][3] = 12'h081;  img[1][4] = w(8, 0);  img[1][5] = 12'h009;
    img[1][9] = w(3, 2);  img[1][10] = w(0, 0);
    img[1][8'h80] = 12'hFFF; img[1][8'h81] = 12'h001;
    // ctx2: count-down loop with both branches
    img[2][0] = w(1, 3);  img[2][1] = w(3, 1);  img[2][2] = w(7, 63);
    img[2][3] = w(6, 2);  img[2][4] = w(0, 0);  img[2][5] = w(5, 1);
    // ctx3: unknown opcode acts as no-op
    img[3][0] = w(63, 0); img[3][1] = w(1, 7);  img[3][2] = w(0, 0);
    // ctx4: never started
    img[4][0] = w(1, 9);
    // ctx5: wrap below zero and back
    img[5][0] = w(3, 1);  img[5][1] = w(2, 1);  img[5][2] = w(3, 1);
    // ctx7: endless long jump to itself
    img[7][0] = w(8, 0);  img[7][1] = 12'h000;
    img[8][0] = w(1, 1);  img[9][0] = w(2, 2);
  endtask

  // monitor: compares each visit against the scoreboard
  initial begin : monitor
    int vis [NCTX];
    int prev;
    bit found;
    prev = -1;
    for (int i = 0; i < NCTX; i++) vis[i] = 0;
    wait (mon_on);
    forever begin
      @(negedge clk);
      if (prev >= 0) begin
        n_checks++;
        if (int'(cur_ctx) != (prev + 1) % NCTX) begin
          n_errors++;
          $display("FAIL R2 rotation: ctx=%0d expected %0d", cur_ctx, (prev + 1) % NCTX);
        end
      end
      prev = int'(cur_ctx);
      found = 1'b0;
      for (int i = 0; i < sb.size() && !found; i++) begin
        if (sb[i].c == int'(cur_ctx) && sb[i].v == vis[cur_ctx]) begin
          found = 1'b1;
          n_checks++;
          if (cur_acc !== sb[i].acc || cur_pc !== sb[i].pc ||
              cur_step !== sb[i].step || cur_halt !== sb[i].halt) begin
            n_errors++;
            $display("FAIL %s ctx%0d visit%0d: acc=%h pc=%h step=%0d halt=%0b expected acc=%h pc=%h step=%0d halt=%0b",
                     sb[i].tag, cur_ctx, sb[i].v, cur_acc, cur_pc, cur_step, cur_halt,
                     sb[i].acc, sb[i].pc, sb[i].step, sb[i].halt);
          end
          sb.delete(i);
        end
      end
      if (cur_ctx < NCTX) vis[cur_ctx]++;
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0; start = '0; tp_we = 1'b0; tp_ctx = '0; tp_addr = '0; tp_data = '0;
    build_images();
    for (int c = 0; c < NCTX; c++) push_expected(c);
    // preload every bank through the test port (R10)
    for (int c = 0; c < NCTX; c++) begin
      for (int a = 0; a < DEP; a++) begin
        @(negedge clk);
        tp_we = 1'b1; tp_ctx = 4'(c); tp_addr = AW'(a); tp_data = img[c][a];
      end
    end
    @(negedge clk);
    tp_we = 1'b0;
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    start = RUN_MASK;
    mon_on = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk);
    start = '0;
    repeat (NV * NCTX) @(negedge clk);
    #1;
    foreach (sb[i]) begin
      n_checks++;
      n_errors++;
      $display("FAIL %s ctx%0d visit%0d: acc=none expected acc=%h", sb[i].tag, sb[i].c, sb[i].v, sb[i].acc);
    end
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule